// File: doc/BRIEF.md
# Watchdog Timer with Selectable Overflow Action

This block is a watchdog built from a free-running prescaler and an 8-bit up-counter. The counter advances on one of eight prescaler taps. When it rolls over from its top value, the block takes the single action picked by the mode field. That action is a one-cycle maskable interrupt request, a one-cycle non-maskable interrupt request, or a fixed-width system reset pulse. In its fourth mode the same hardware runs as an interval timer, and each rollover produces a one-cycle timer interrupt.

Software drives the block through a two-address write port and reads the control value back on a parallel output. Address 0 holds the control register. A write of any data to address 1 is a kick, which restarts the whole count chain. If software starts the block in reset mode, the control register is frozen until the next hardware reset, so a runaway program cannot switch the watchdog off. The CPU, the interrupt controller and the reset distribution network sit outside this block.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x00 and `tmr_irq`, `wdt_irq`, `wdt_nmi` and `sys_rst` are all low.
- R2: Control register layout at address 0: bits [2:0] `sel` choose the tap, bits [4:3] `mode`, bit 7 `run`; `ctrl_rd` returns those bits and zeros elsewhere. Tap `sel` = 0..6 divides the clock by 2^(3+sel) and `sel` = 7 by 2^11. After the write that sets `run`, the first overflow action appears 256·2^shift cycles later.
- R3: The counter is 8 bits wide and wraps to zero on overflow. While running without a kick, actions recur every 256·2^shift cycles.
- R4: In mode 00 (interval timer) each overflow pulses `tmr_irq` for exactly one cycle, and no other output moves.
- R5: In mode 01 each overflow pulses `wdt_irq` for exactly one cycle, and no other output moves.
- R6: In mode 10 each overflow pulses `wdt_nmi` for exactly one cycle, and no other output moves.
- R7: In mode 11 each overflow drives `sys_rst` high for exactly 4 consecutive cycles.
- R8: A write to address 1 (kick) clears both the prescaler and the counter, so the next action comes 256·2^shift cycles after the kick.
- R9: While `run` is set with mode 11, writes to address 0 are ignored: the readback is unchanged and counting continues. The freeze lasts until `rst_n` is asserted.
- R10: Clearing `run` stops the count and clears the prescaler and the counter. A later restart waits a full 256·2^shift cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = kick |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register readback |
| tmr_irq | output | 1 | Interval-timer interrupt pulse |
| wdt_irq | output | 1 | Watchdog maskable interrupt pulse |
| wdt_nmi | output | 1 | Watchdog non-maskable interrupt pulse |
| sys_rst | output | 1 | Watchdog reset pulse, 4 cycles |

## Verification
The bench checks the exact cycle of every action, so an off-by-one tap decode or a prescaler that is not cleared shows up as a shifted deadline. A kick placed late in a period must push the deadline back by a full period. A design that cleared only the counter would fire early. A design that ignored the kick would fire at the original time. An unlock attempt is made part-way through reset mode. A leaky lock would show as a changed readback and a missing reset pulse. A reset pulse that is one cycle short or long is caught by its measured width. A design that kept stale prescaler state across stop and restart would fire early on the restarted period.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned SEL_W     = 3;
    localparam int unsigned NUM_TAPS  = 1 << SEL_W;
    localparam int unsigned TAP_FIRST = 3;
    localparam int unsigned TAP_LAST  = 11;
    localparam int unsigned PRE_W     = TAP_LAST;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_WD_IRQ   = 2'b01,
        MODE_WD_NMI   = 2'b10,
        MODE_WD_RST   = 2'b11
    } wdg_mode_e;

    typedef struct packed {
        logic             run;
        wdg_mode_e        mode;
        logic [SEL_W-1:0] sel;
    } wdg_ctrl_t;

    // Division exponent of each tap: consecutive from TAP_FIRST, last tap jumps to TAP_LAST.
    function automatic int unsigned tap_shift(input int unsigned idx);
        return (idx == NUM_TAPS - 1) ? TAP_LAST : TAP_FIRST + idx;
    endfunction

endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
#(
    parameter int unsigned PW = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PW-1:0] div;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [NUM_TAPS-1:0] tap_hit;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int unsigned SH = tap_shift(i);
        assign tap_hit[i] = &st_q.div[SH-1:0];
    end

    always_comb begin
        st_d = st_q;
        tick_o = 1'b0;
        if (!run_i || clr_i) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
            tick_o   = tap_hit[sel_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a kick leaves the prescaler at zero
    assert_kick_clears_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.div == '0));

    // R10: a stopped block holds the prescaler at zero
    assert_stop_clears_pre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.div == '0));

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic ovf_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = 1'b0;
        if (!run_i || clr_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            ovf_o    = (st_q.cnt == CNT_TOP);
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the counter wraps to zero after overflow
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (st_q.cnt == '0));

    // R8: a kick clears the counter
    assert_kick_clears_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdg_action.sv
module wdg_action
    import wdg_pkg::*;
#(
    parameter int unsigned RST_PULSE = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ovf_i,
    input  wdg_mode_e mode_i,
    output logic      tmr_irq_o,
    output logic      wdt_irq_o,
    output logic      wdt_nmi_o,
    output logic      sys_rst_o
);

    localparam int unsigned RC_W = $clog2(RST_PULSE + 1);

    typedef struct packed {
        logic            tmr;
        logic            irq;
        logic            nmi;
        logic [RC_W-1:0] rst_left;
    } act_state_t;

    act_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tmr = ovf_i && (mode_i == MODE_INTERVAL);
        st_d.irq = ovf_i && (mode_i == MODE_WD_IRQ);
        st_d.nmi = ovf_i && (mode_i == MODE_WD_NMI);
        if (ovf_i && (mode_i == MODE_WD_RST)) begin
            st_d.rst_left = RC_W'(RST_PULSE);
        end else if (st_q.rst_left != '0) begin
            st_d.rst_left = st_q.rst_left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_irq_o = st_q.tmr;
    assign wdt_irq_o = st_q.irq;
    assign wdt_nmi_o = st_q.nmi;
    assign sys_rst_o = (st_q.rst_left != '0);

    // R5: at most one interrupt-type action at a time
    assert_single_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmr_irq_o, wdt_irq_o, wdt_nmi_o}));

    // R6: a non-maskable request only follows an overflow
    assert_nmi_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_nmi_o |-> $past(ovf_i));

    // R7: the reset pulse lasts beyond its first cycle
    assert_rst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |=> sys_rst_o);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned RST_PULSE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_rd,
    output logic       tmr_irq,
    output logic       wdt_irq,
    output logic       wdt_nmi,
    output logic       sys_rst
);

    typedef struct packed {
        wdg_ctrl_t ctrl;
    } top_state_t;

    top_state_t st_d, st_q;
    logic locked;
    logic kick;
    logic tick;
    logic ovf;

    assign locked = st_q.ctrl.run && (st_q.ctrl.mode == MODE_WD_RST);
    assign kick   = wr_en && wr_addr;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_addr && !locked) begin
            st_d.ctrl = wdg_ctrl_t'({wr_data[7], wr_data[4:3], wr_data[SEL_W-1:0]});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_rd = {st_q.ctrl.run, 2'b00, st_q.ctrl.mode, st_q.ctrl.sel};

    wdg_prescale #(.PW(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.ctrl.run),
        .clr_i  (kick),
        .sel_i  (st_q.ctrl.sel),
        .tick_o (tick)
    );

    wdg_count #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.ctrl.run),
        .clr_i  (kick),
        .tick_i (tick),
        .ovf_o  (ovf)
    );

    wdg_action #(.RST_PULSE(RST_PULSE)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_i     (ovf),
        .mode_i    (st_q.ctrl.mode),
        .tmr_irq_o (tmr_irq),
        .wdt_irq_o (wdt_irq),
        .wdt_nmi_o (wdt_nmi),
        .sys_rst_o (sys_rst)
    );

    // R9: once frozen, the control register never changes until reset
    assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> $stable(st_q.ctrl));

    // R10: no action while stopped
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_q.ctrl.run) |-> !(tmr_irq || wdt_irq || wdt_nmi || $rose(sys_rst)));

endmodule

// File: tb/test_wdog_guard.sv
module test_wdog_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_rd;
    logic       tmr_irq, wdt_irq, wdt_nmi, sys_rst;

    wdog_guard i_wdog_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .tmr_irq(tmr_irq), .wdt_irq(wdt_irq), .wdt_nmi(wdt_nmi),
        .sys_rst(sys_rst)
    );

    always #10 clk = ~clk;

    localparam int KIND_TMR = 1;
    localparam int KIND_IRQ = 2;
    localparam int KIND_NMI = 3;
    localparam int KIND_RST = 4;

    typedef struct {
        int     kind;
        longint at;
    } ev_t;

    ev_t    exp_q[$];
    longint cyc = 0;
    longint last_c = 0;
    longint last_ev_cyc = -1;
    int     last_ev_kind = 0;
    int     errors = 0;
    int     checks = 0;
    logic   prev_rst = 1'b0;
    int     rst_width = 0;
    int     last_width = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string req_of(input int kind);
        case (kind)
            KIND_TMR: return "R4";
            KIND_IRQ: return "R5";
            KIND_NMI: return "R6";
            default:  return "R7";
        endcase
    endfunction

    function automatic longint period(input int sel);
        int sh;
        sh = (sel == 7) ? 11 : 3 + sel;
        return longint'(256) << sh;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic take(input int kind);
        ev_t e;
        checks++;
        last_ev_cyc  = cyc;
        last_ev_kind = kind;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected action kind=%0d at cycle %0d, expected none",
                     req_of(kind), kind, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                errors++;
                $display("FAIL %s/R2: actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                         req_of(kind), kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // Monitor: samples on the falling edge and scores every action.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tmr_irq) take(KIND_TMR);
            if (wdt_irq) take(KIND_IRQ);
            if (wdt_nmi) take(KIND_NMI);
            if (sys_rst && !prev_rst) begin
                take(KIND_RST);
                rst_width = 1;
            end else if (sys_rst) begin
                rst_width++;
            end else if (prev_rst) begin
                last_width = rst_width;
                check("R7 pulse width", rst_width, 4);
            end
            prev_rst = sys_rst;
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 last_c = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input int kind, input longint at);
        ev_t e;
        e.kind = kind; e.at = at;
        exp_q.push_back(e);
    endtask

    task automatic wait_until(input longint c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        while (exp_q.size() != 0) begin
            ev_t e;
            e = exp_q.pop_front();
            check({req_of(e.kind), " missing action"}, 0, e.at);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint ca, cb, cc, ck, cd, ce;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctrl", ctrl_rd, 8'h00);
        check("R1 outputs", {tmr_irq, wdt_irq, wdt_nmi, sys_rst}, 4'b0000);

        // Interval timer, fastest tap; second event proves wrap (R3)
        wr(1'b0, 8'h80); ca = last_c;
        check("R2 readback", ctrl_rd, 8'h80);
        push(KIND_TMR, ca + period(0));
        push(KIND_TMR, ca + 2 * period(0));
        wait_until(ca + 2 * period(0) + 2);
        check("R3 recurrence", last_ev_cyc, ca + 2 * period(0));
        wait_until(ca + 2 * period(0) + 700);

        // Stop mid-period, restart: full period expected (R10)
        wr(1'b0, 8'h00); exp_q.delete();
        repeat (10) @(negedge clk);
        wr(1'b0, 8'h80); cb = last_c;
        push(KIND_TMR, cb + period(0));
        wait_until(cb + period(0) + 2);
        check("R10 restart period", last_ev_cyc, cb + period(0));
        wr(1'b0, 8'h00); exp_q.delete();

        // Watchdog maskable, tap 1, late kick (R5, R8)
        wr(1'b0, 8'h89); cc = last_c;
        push(KIND_IRQ, cc + period(1));
        wait_until(cc + period(1) - 600);
        wr(1'b1, 8'h00); ck = last_c;
        exp_q.delete();
        push(KIND_IRQ, ck + period(1));
        wait_until(ck + period(1) + 3);
        check("R8 kick deadline", last_ev_cyc, ck + period(1));
        check("R5 kind", last_ev_kind, KIND_IRQ);
        wr(1'b0, 8'h00); exp_q.delete();

        // Watchdog NMI, tap 6 (R6, R2)
        wr(1'b0, 8'h96); cd = last_c;
        check("R2 readback nmi", ctrl_rd, 8'h96);
        push(KIND_NMI, cd + period(6));
        wait_until(cd + period(6) + 3);
        check("R6 kind", last_ev_kind, KIND_NMI);
        wr(1'b0, 8'h00); exp_q.delete();

        // Watchdog reset with lock (R7, R9)
        wr(1'b0, 8'h98); ce = last_c;
        push(KIND_RST, ce + period(0));
        wait_until(ce + 500);
        wr(1'b0, 8'h00);
        check("R9 locked readback", ctrl_rd, 8'h98);
        wr(1'b0, 8'h81);
        check("R9 locked readback 2", ctrl_rd, 8'h98);
        wait_until(ce + period(0) + 10);
        check("R7 kind", last_ev_kind, KIND_RST);
        check("R7 width seen", last_width, 4);

        // Hardware reset releases the lock (R9)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ctrl after reset", ctrl_rd, 8'h00);
        check("R9 sys_rst after reset", sys_rst, 0);
        prev_rst = 1'b0;
        wr(1'b0, 8'h05);
        check("R9 writable after reset", ctrl_rd, 8'h05);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule